// File: doc/BRIEF.md
# Complex Oscillator Down-Mixer

This block moves a sampled signal from a digital intermediate frequency down to baseband. A 32-bit phase accumulator steps by a programmable tuning word once for each accepted input sample. A programmable offset word is added to that phase, so several mixers fed the same stream can hold a known phase relationship to each other. The top bits of the resulting phase address a quarter-wave sine table. The sine and cosine values then multiply the incoming sample.

In real mode a single 16-bit sample produces an in-phase product (times cosine) and a quadrature product (times negative sine). In complex mode an I/Q pair is rotated by the conjugate oscillator phasor. Two optional dither sources can be enabled separately to break up oscillator spurs. Both come from a free-running maximal-length shift register. One perturbs the phase below the table resolution and the other adds an LSB to the sine and cosine amplitudes. A sync input forces the accumulator back to zero, which aligns the oscillator to an external event. Results are rounded to 18 bits with saturation and leave three register stages after the sample enters.

Top module: `nco_mixer`

## Requirements
- R1: While rst_n is low at a rising edge, out_valid, out_i and out_q become 0, the tuning word, offset word and control bits become 0, the accumulator becomes 0 and the dither register becomes 15'h0001.
- R2: A write with cfg_we high loads cfg_wdata into the tuning word at cfg_addr 0 and into the offset word at cfg_addr 1. At cfg_addr 2 it loads the control bits: bit 0 phase dither enable, bit 1 amplitude dither enable, bit 2 complex mode. A write to cfg_addr 3 changes nothing. A write applies to samples accepted at later edges, not to a sample accepted at the same edge.
- R3: The phase used for an accepted sample is acc + offset (mod 2^32). After each accepted sample acc becomes that sample's acc value plus the tuning word (mod 2^32). acc does not change on cycles without in_valid.
- R4: A sync_in pulse on a cycle without in_valid makes the next accepted sample use acc = 0. sync_in together with in_valid makes that same sample use acc = 0. Either way the following accumulator value is the tuning word.
- R5: Bits [31:20] of the final phase form the table address a. The sine value is round(32767*sin(2*pi*a/4096)) and the cosine value is round(32767*cos(2*pi*a/4096)), with the magnitude rounded half up.
- R6: In real mode (control bit 2 = 0), with x = in_i as signed, the I product is x*cos and the Q product is -(x*sin). in_q is ignored.
- R7: In complex mode (control bit 2 = 1), with xi = in_i and xq = in_q as signed, the I product is xi*cos + xq*sin and the Q product is xq*cos - xi*sin.
- R8: Each product p is output as floor((p + 4096) / 8192), clipped to the range [-131072, 131071].
- R9: With phase dither on, the dither register value shifted left by 5 is added to acc + offset before the address is taken.
- R10: With amplitude dither on, dither bit 0 is added to the cosine value and dither bit 1 to the sine value, before the multiply and before the sine is negated.
- R11: The dither register is 15 bits, starts at 15'h0001, and is the value current when a sample is accepted. On each accepted sample it shifts left by one, and the new bit 0 is the XOR of old bits 14 and 13. It does not move on cycles without in_valid.
- R12: A sample accepted at rising edge k sets out_valid, out_i and out_q after edge k+2. out_valid is low on cycles that carry no result, and out_i and out_q hold their last values there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Input sample present |
| sync_in | input | 1 | Accumulator clear request |
| in_i | input | 16 | Real sample, or in-phase part in complex mode |
| in_q | input | 16 | Quadrature part in complex mode |
| out_valid | output | 1 | Mixed result present |
| out_i | output | 18 | In-phase result |
| out_q | output | 18 | Quadrature result |

## Verification
The bench sweeps the table address across all four quadrants, including the points where the sine magnitude is read mirrored at index 1024. A quadrant or mirroring error would give wrong signs or a value off by one table step there. It drives full-scale complex pairs at 45 degrees, which push the I result above both 18-bit limits, so a wrapping saturator would show a large value of the wrong sign. It sends sync both alone and together with a sample, and sends samples with gaps in valid. Clearing the accumulator one sample late, or advancing the accumulator or the dither register on idle cycles, would shift every later phase. Configuration writes are timed so that a design applying a new word to the sample accepted at the same edge produces a mismatch.

// File: rtl/nco_pkg.sv
// Shared types and elaboration-time helpers for the oscillator mixer.
// Assumes the table-size and amplitude parameters passed to the helper
// give a magnitude that fits in an int.
package nco_pkg;

    // Control bits, one per enable; bit 0 is phase dither.
    typedef struct packed {
        logic cplx;      // bit 2: complex input mode
        logic amp_dith;  // bit 1: amplitude dither enable
        logic ph_dith;   // bit 0: phase dither enable
    } nco_ctl_t;

    localparam real TWO_PI_HALF = 3.141592653589793;

    // Rounded sine magnitude for one quarter-wave table entry.
    function automatic int quarter_sine(input int k, input int abits, input int amp_w);
        real ang;
        real full;
        ang  = 2.0 * TWO_PI_HALF * real'(k) / real'(1 << abits);
        full = real'((1 << (amp_w - 1)) - 1);
        return $rtoi(full * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/nco_lfsr.sv
// Dither source: Fibonacci shift register that moves one step when adv is
// high. Assumes TAP_A/TAP_B give a maximal-length sequence for W and that
// SEED is non-zero.
module nco_lfsr #(
    parameter int W     = 15,
    parameter int TAP_A = 14,
    parameter int TAP_B = 13,
    parameter int SEED  = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] state
);

    // Shift one place per advance, feeding back the XOR of the two taps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= W'(SEED);
        else if (adv)
            state <= {state[W-2:0], state[TAP_A] ^ state[TAP_B]};
    end

    // R11
    property lfsr_hold_p;
        @(posedge clk) disable iff (!rst_n) !adv |=> $stable(state);
    endproperty
    lfsr_hold_chk: assert property (lfsr_hold_p);

    // R11
    property lfsr_nonzero_p;
        @(posedge clk) disable iff (!rst_n) adv |=> (state != '0);
    endproperty
    lfsr_nonzero_chk: assert property (lfsr_nonzero_p);

endmodule

// File: rtl/nco_sincos.sv
// Quarter-wave sine/cosine lookup with one output register. The table is
// built at elaboration from the package helper. Assumes ABITS >= 3. The
// outputs are signed and one bit wider than AMP_W so the amplitude dither
// LSB cannot overflow.
module nco_sincos #(
    parameter int ABITS = 12,
    parameter int AMP_W = 16,
    localparam int TW   = AMP_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [ABITS-1:0]     addr,
    input  logic [1:0]           dith,   // [0] cosine LSB, [1] sine LSB
    output logic signed [TW-1:0] sin_o,
    output logic signed [TW-1:0] cos_o
);

    localparam int QN = 1 << (ABITS - 2);

    logic [AMP_W-2:0] qtab [0:QN];

    // One constant entry per quarter-wave point, endpoints included.
    for (genvar k = 0; k <= QN; k++) begin : g_tab
        assign qtab[k] = (AMP_W-1)'(nco_pkg::quarter_sine(k, ABITS, AMP_W));
    end

    logic [1:0]             quad;
    logic [ABITS-2:0]       fwd, rev;
    logic signed [TW-1:0]   mf, mr, s_c, c_c;

    // Fold the address into the quarter wave and rebuild signs per quadrant.
    always_comb begin
        quad = addr[ABITS-1 -: 2];
        fwd  = {1'b0, addr[ABITS-3:0]};
        rev  = (ABITS-1)'(QN) - fwd;
        mf   = TW'(qtab[fwd]);
        mr   = TW'(qtab[rev]);
        case (quad)
            2'd0:    begin s_c =  mf; c_c =  mr; end
            2'd1:    begin s_c =  mr; c_c = -mf; end
            2'd2:    begin s_c = -mf; c_c = -mr; end
            default: begin s_c = -mr; c_c =  mf; end
        endcase
    end

    // Register the dithered trig values for the multiply stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sin_o <= '0;
            cos_o <= '0;
        end else if (en) begin
            sin_o <= s_c + TW'(dith[1]);
            cos_o <= c_c + TW'(dith[0]);
        end
    end

endmodule

// File: rtl/nco_cmul.sv
// Mixer multiply, round and saturate, with one output register. In real
// mode only xi is used. Assumes TRIG_W-bit trig values are scaled to
// 2^(TRIG_W-2) full scale; SHIFT is set by the top accordingly.
module nco_cmul #(
    parameter int IN_W   = 16,
    parameter int TRIG_W = 17,
    parameter int OUT_W  = 18,
    parameter int SHIFT  = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    cplx,
    input  logic signed [IN_W-1:0]  xi,
    input  logic signed [IN_W-1:0]  xq,
    input  logic signed [TRIG_W-1:0] c,
    input  logic signed [TRIG_W-1:0] s,
    output logic signed [OUT_W-1:0] i_o,
    output logic signed [OUT_W-1:0] q_o
);

    localparam int PW = IN_W + TRIG_W + 1;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (SHIFT - 1);
    localparam logic signed [PW-1:0] OMAX = (PW'(1) <<< (OUT_W - 1)) - PW'(1);
    localparam logic signed [PW-1:0] OMIN = -OMAX - PW'(1);

    // Round half up, then clip into the output range.
    function automatic logic signed [OUT_W-1:0] rnd_sat(input logic signed [PW-1:0] p);
        logic signed [PW-1:0] r;
        r = (p + HALF) >>> SHIFT;
        if (r > OMAX)      return OMAX[OUT_W-1:0];
        else if (r < OMIN) return OMIN[OUT_W-1:0];
        else               return r[OUT_W-1:0];
    endfunction

    logic signed [PW-1:0] pi, pq;

    // Form the real or complex mixer products at full precision.
    always_comb begin
        if (cplx) begin
            pi = PW'(xi) * PW'(c) + PW'(xq) * PW'(s);
            pq = PW'(xq) * PW'(c) - PW'(xi) * PW'(s);
        end else begin
            pi = PW'(xi) * PW'(c);
            pq = -(PW'(xi) * PW'(s));
        end
    end

    // Register the rounded and saturated results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_o <= '0;
            q_o <= '0;
        end else if (en) begin
            i_o <= rnd_sat(pi);
            q_o <= rnd_sat(pq);
        end
    end

endmodule

// File: rtl/nco_mixer.sv
// Complex oscillator down-mixer top. It holds the configuration words,
// the phase accumulator with sync clear and the dither source, and chains
// three register stages: phase, table, multiply. It assumes in_valid
// marks one sample per cycle and that configuration writes may come at
// any time.
module nco_mixer #(
    parameter int PHASE_W = 32,
    parameter int IN_W    = 16,
    parameter int OUT_W   = 18,
    parameter int ABITS   = 12,
    parameter int AMP_W   = 16,
    parameter int DITH_W  = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_addr,
    input  logic [PHASE_W-1:0]       cfg_wdata,
    input  logic                     in_valid,
    input  logic                     sync_in,
    input  logic [IN_W-1:0]          in_i,
    input  logic [IN_W-1:0]          in_q,
    output logic                     out_valid,
    output logic [OUT_W-1:0]         out_i,
    output logic [OUT_W-1:0]         out_q
);

    import nco_pkg::*;

    localparam int TW       = AMP_W + 1;
    localparam int PD_SHIFT = PHASE_W - ABITS - DITH_W;
    localparam int SHIFT    = (AMP_W - 1) - (OUT_W - IN_W);

    logic [PHASE_W-1:0] ftw_r, off_r, acc_r, acc_base, ph_sum, ph_dith;
    nco_ctl_t           ctl_r;
    logic               sync_pend;
    logic [DITH_W-1:0]  lfsr_q;

    // Stage registers
    logic                    v1, v2, v3;
    logic [ABITS-1:0]        addr1;
    logic [1:0]              ad1;
    logic                    cplx1, cplx2;
    logic signed [IN_W-1:0]  xi1, xq1, xi2, xq2;
    logic signed [TW-1:0]    sin2, cos2;
    logic signed [OUT_W-1:0] oi, oq;

    // Load configuration words from the write port; address 3 is unused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftw_r <= '0;
            off_r <= '0;
            ctl_r <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                2'd0:    ftw_r <= cfg_wdata;
                2'd1:    off_r <= cfg_wdata;
                2'd2:    ctl_r <= nco_ctl_t'(cfg_wdata[2:0]);
                default: ;
            endcase
        end
    end

    // Select accumulator start and build the dithered phase for this sample.
    always_comb begin
        acc_base = (sync_in || sync_pend) ? '0 : acc_r;
        ph_dith  = ctl_r.ph_dith ? (PHASE_W'(lfsr_q) << PD_SHIFT) : '0;
        ph_sum   = acc_base + off_r + ph_dith;
    end

    // Advance the accumulator per sample and remember a lone sync pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_r     <= '0;
            sync_pend <= 1'b0;
        end else if (in_valid) begin
            acc_r     <= acc_base + ftw_r;
            sync_pend <= 1'b0;
        end else if (sync_in) begin
            sync_pend <= 1'b1;
        end
    end

    nco_lfsr #(.W(DITH_W), .TAP_A(DITH_W-1), .TAP_B(DITH_W-2), .SEED(1)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .state (lfsr_q)
    );

    // Stage 1: capture table address, dither bits and the sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; addr1 <= '0; ad1 <= '0; cplx1 <= 1'b0; xi1 <= '0; xq1 <= '0;
        end else begin
            v1 <= in_valid;
            if (in_valid) begin
                addr1 <= ph_sum[PHASE_W-1 -: ABITS];
                ad1   <= ctl_r.amp_dith ? lfsr_q[1:0] : 2'b00;
                cplx1 <= ctl_r.cplx;
                xi1   <= in_i;
                xq1   <= in_q;
            end
        end
    end

    nco_sincos #(.ABITS(ABITS), .AMP_W(AMP_W)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (v1),
        .addr  (addr1),
        .dith  (ad1),
        .sin_o (sin2),
        .cos_o (cos2)
    );

    // Stage 2: carry the sample and mode alongside the table output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2 <= 1'b0; cplx2 <= 1'b0; xi2 <= '0; xq2 <= '0;
        end else begin
            v2 <= v1;
            if (v1) begin
                cplx2 <= cplx1;
                xi2   <= xi1;
                xq2   <= xq1;
            end
        end
    end

    nco_cmul #(.IN_W(IN_W), .TRIG_W(TW), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (v2),
        .cplx  (cplx2),
        .xi    (xi2),
        .xq    (xq2),
        .c     (cos2),
        .s     (sin2),
        .i_o   (oi),
        .q_o   (oq)
    );

    // Stage 3: result valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) v3 <= 1'b0;
        else        v3 <= v2;
    end

    assign out_valid = v3;
    assign out_i     = oi;
    assign out_q     = oq;

    // Cycles since reset, saturating, so latency checks never look before reset.
    logic [1:0] age_r;
    always_ff @(posedge clk) begin
        if (!rst_n)           age_r <= 2'd0;
        else if (age_r != 2'd3) age_r <= age_r + 2'd1;
    end

    // R12
    property latency_p;
        @(posedge clk) disable iff (!rst_n) (age_r == 2'd3) |-> (out_valid == $past(in_valid, 3));
    endproperty
    latency_chk: assert property (latency_p);

    // R4
    property sync_clear_p;
        @(posedge clk) disable iff (!rst_n) (in_valid && sync_in) |=> (acc_r == $past(ftw_r));
    endproperty
    sync_clear_chk: assert property (sync_clear_p);

    // R3
    property acc_hold_p;
        @(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(acc_r);
    endproperty
    acc_hold_chk: assert property (acc_hold_p);

    // R2
    property ftw_load_p;
        @(posedge clk) disable iff (!rst_n) (cfg_we && cfg_addr == 2'd0) |=> (ftw_r == $past(cfg_wdata));
    endproperty
    ftw_load_chk: assert property (ftw_load_p);

    // R2
    property addr3_ignored_p;
        @(posedge clk) disable iff (!rst_n) (cfg_we && cfg_addr == 2'd3) |=> ($stable(ftw_r) && $stable(off_r) && $stable(ctl_r));
    endproperty
    addr3_ignored_chk: assert property (addr3_ignored_p);

endmodule

// File: tb/tb_nco_mixer.sv
// Self-checking bench: a behavioural model computes every result from the
// requirements and a 3-deep queue lines it up with the design output.
module tb_nco_mixer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        sync_in = 1'b0;
    logic [15:0] in_i = '0;
    logic [15:0] in_q = '0;
    logic        out_valid;
    logic [17:0] out_i, out_q;

    always #4 clk = ~clk;   // 125 MHz

    nco_mixer dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .sync_in(sync_in),
        .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    int    tests = 0;
    int    fails = 0;
    int    cyc   = 0;
    string cur_req = "R6";

    // ---------------- reference model ----------------
    logic [31:0] m_acc, m_ftw, m_off;
    logic [2:0]  m_ctl;
    logic [14:0] m_lfsr;
    bit          m_pend;
    bit          pv [0:2];
    int          pi_q [0:2];
    int          pq_q [0:2];

    function automatic int trig(input int a, input bit is_cos);
        int p, k, m;
        p = is_cos ? ((a + 1024) % 4096) : a;
        k = p % 2048;
        if (k > 1024) k = 2048 - k;
        m = $rtoi(32767.0 * $sin(2.0 * 3.141592653589793 * real'(k) / 4096.0) + 0.5);
        return (p >= 2048) ? -m : m;
    endfunction

    function automatic int rsat(input longint p);
        longint r;
        r = (p + 4096) >>> 13;
        if (r > 131071)  r = 131071;
        if (r < -131072) r = -131072;
        return int'(r);
    endfunction

    always @(posedge clk) begin
        logic [31:0] a, ph;
        int addr, c, s, ni, nq;
        longint xi, xq, pi, pq;
        bit nv;
        if (!rst_n) begin
            m_acc = '0; m_ftw = '0; m_off = '0; m_ctl = '0; m_lfsr = 15'h0001; m_pend = 0;
            for (int j = 0; j < 3; j++) begin pv[j] = 0; pi_q[j] = 0; pq_q[j] = 0; end
        end else begin
            nv = 0; ni = 0; nq = 0;
            if (in_valid) begin
                a  = (sync_in || m_pend) ? 32'd0 : m_acc;
                ph = a + m_off + (m_ctl[0] ? ({17'd0, m_lfsr} << 5) : 32'd0);
                addr = int'(ph[31:20]);
                c = trig(addr, 1) + ((m_ctl[1] && m_lfsr[0]) ? 1 : 0);
                s = trig(addr, 0) + ((m_ctl[1] && m_lfsr[1]) ? 1 : 0);
                xi = longint'($signed(in_i));
                xq = longint'($signed(in_q));
                if (m_ctl[2]) begin
                    pi = xi * c + xq * s;
                    pq = xq * c - xi * s;
                end else begin
                    pi = xi * c;
                    pq = -(xi * s);
                end
                ni = rsat(pi); nq = rsat(pq); nv = 1;
                m_acc  = a + m_ftw;
                m_pend = 0;
                m_lfsr = {m_lfsr[13:0], m_lfsr[14] ^ m_lfsr[13]};
            end else if (sync_in) begin
                m_pend = 1;
            end
            if (cfg_we) begin
                case (cfg_addr)
                    2'd0: m_ftw = cfg_wdata;
                    2'd1: m_off = cfg_wdata;
                    2'd2: m_ctl = cfg_wdata[2:0];
                    default: ;
                endcase
            end
            pv[2] = pv[1]; pi_q[2] = pi_q[1]; pq_q[2] = pq_q[1];
            pv[1] = pv[0]; pi_q[1] = pi_q[0]; pq_q[1] = pq_q[0];
            pv[0] = nv;    pi_q[0] = ni;      pq_q[0] = nq;
        end
    end

    // Compare on every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            tests++;
            if (out_valid !== pv[2]) begin
                fails++;
                $display("FAIL R12 out_valid actual=%0b expected=%0b", out_valid, pv[2]);
            end else if (pv[2]) begin
                tests++;
                if ($signed(out_i) != pi_q[2] || $signed(out_q) != pq_q[2]) begin
                    fails++;
                    $display("FAIL %s I/Q actual=%0d/%0d expected=%0d/%0d",
                             cur_req, $signed(out_i), $signed(out_q), pi_q[2], pq_q[2]);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d cycles expected<100000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic push(input int xi, input int xq, input bit sy);
        in_valid = 1'b1; in_i = xi[15:0]; in_q = xq[15:0]; sync_in = sy;
        @(negedge clk);
        in_valid = 1'b0; sync_in = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rnd_burst(input int n, input bit gaps);
        for (int k = 0; k < n; k++) begin
            push($urandom_range(0, 65535), $urandom_range(0, 65535), 1'b0);
            if (gaps && (k % 3 == 0)) idle(1 + (k % 2));
        end
    endtask

    initial begin
        // R1: reset state
        idle(3);
        tests++;
        if (out_valid !== 1'b0 || out_i !== '0 || out_q !== '0) begin
            fails++;
            $display("FAIL R1 reset outputs actual=%0b/%0h/%0h expected=0/0/0", out_valid, out_i, out_q);
        end
        rst_n = 1'b1;
        idle(1);
        tests++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 valid after reset actual=%0b expected=0", out_valid);
        end

        // R6: zero phase, real mode, various levels (also confirms R1 zero config)
        cur_req = "R6";
        push(1000, 5, 0); push(-20000, 0, 0); push(32767, -1, 0); push(-32768, 7, 0);
        idle(4);

        // R3: accumulating phase, then sparse valid so idle cycles must not advance
        cur_req = "R3";
        cfg(2'd0, 32'h0123_4567);
        rnd_burst(60, 0);
        rnd_burst(30, 1);
        idle(4);

        // R2: offset word, ignored address 3, same-edge write timing
        cur_req = "R2";
        cfg(2'd1, 32'h4000_0000);
        rnd_burst(10, 0);
        cfg(2'd3, 32'hDEAD_BEEF);
        rnd_burst(10, 0);
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'h0800_0000;
        push(12345, 0, 0);
        cfg_we = 1'b0;
        rnd_burst(10, 0);
        idle(4);

        // R4: sync alone, then sync with a sample
        cur_req = "R4";
        sync_in = 1'b1; idle(1); sync_in = 1'b0;
        idle(3);
        rnd_burst(5, 0);
        push(20000, 0, 1);
        rnd_burst(5, 0);
        push(-15000, 0, 1);
        push(9000, 0, 1);
        idle(4);

        // R5: table sweep over all quadrants
        cur_req = "R5";
        cfg(2'd1, 32'h0);
        cfg(2'd0, 32'h0030_0000);
        push(0, 0, 1);
        for (int k = 0; k < 1400; k++) push(32767, 0, 0);
        cfg(2'd0, 32'h0010_0000);
        push(0, 0, 1);
        for (int k = 0; k < 8; k++) push(-32768, 0, 0);
        idle(4);

        // R7: complex rotation
        cur_req = "R7";
        cfg(2'd2, 32'h4);
        cfg(2'd0, 32'h0123_4567);
        rnd_burst(80, 0);
        idle(4);

        // R8: saturation both ways at 45 degrees, full scale
        cur_req = "R8";
        cfg(2'd0, 32'h0);
        cfg(2'd1, 32'h2000_0000);
        push(0, 0, 1);
        push(32767, 32767, 0); push(-32768, -32768, 0); push(32767, -32768, 0);
        cfg(2'd2, 32'h0);
        cfg(2'd1, 32'h8000_0000);
        push(-32768, 0, 1); push(32767, 0, 0);
        idle(4);

        // R9: phase dither
        cur_req = "R9";
        cfg(2'd1, 32'h0);
        cfg(2'd0, 32'h0123_4567);
        cfg(2'd2, 32'h1);
        rnd_burst(100, 0);
        idle(4);

        // R10: amplitude dither
        cur_req = "R10";
        cfg(2'd2, 32'h2);
        rnd_burst(100, 0);
        idle(4);

        // R11: both dithers, complex, with gaps in valid
        cur_req = "R11";
        cfg(2'd2, 32'h7);
        rnd_burst(120, 1);
        idle(6);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule